// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits beside a small processor core and decides which of five hardware interrupt sources is served next. One source is a non-maskable trap. Three are restart requests that each send control to a fixed vector address. The fifth is a general request whose vector comes from a restart opcode supplied by the interrupting device. The block keeps a global interrupt enable and a per-source mask for the three restart requests. It presents the core with a single `pending` indication.

When the core sees `pending`, it pulses `accept`. For the trap and the three restart sources, the block registers the fixed vector address. It pulses `vec_valid` in the cycle that follows the accept. For the general request, the block instead runs an acknowledge phase: `inta` is driven high for `ACK_CYC` cycles in place of a read strobe, and the program counter of the core is meant to stay put during that phase. The restart opcode on `ack_opcode` is sampled in the last `inta` cycle. The vector derived from that opcode is then presented with `vec_valid`. Any accepted interrupt clears the global enable.

Top module: `vint_ctrl`

## Requirements
- R1: After a synchronous reset the block drives `pending`, `inta` and `vec_valid` low and `vector` zero. The global enable is cleared and all three restart mask bits are set, so the restart inputs raise no `pending` until software unmasks them.
- R2: The fixed priority is trap, then edge restart, then middle restart, then low restart, then general request. One cycle after an `accept` taken while `pending` is high, `vec_valid` is high and `vector` holds the winner's address: trap 0x0024, edge restart 0x003C, middle restart 0x0034, low restart 0x002C.
- R3: The trap ignores the masks and the global enable. It qualifies only when `trap_in` has risen and is still high in the following cycle. A trap that falls before then is dropped. A trap held high after being served does not request again until it falls and rises once more.
- R4: A rising edge on `irq_edge_in` is latched even while that source is masked or disabled. The latched request stays until it is served or `edge_clr` is pulsed. A level held high after service does not request again.
- R5: `irq_mid_in` and `irq_low_in` are level sensitive. Each requests only while it is high, its mask bit is clear and the global enable is set.
- R6: A `mask_wr` pulse loads `mask_data` into the masks. Bit 2 masks the edge restart, bit 1 the middle restart and bit 0 the low restart. A 1 means masked.
- R7: `ie_set` sets the global enable and `ie_clr` clears it. An accepted interrupt clears it and wins over an `ie_set` in the same cycle. The general request raises `pending` only while the enable is set.
- R8: Accepting the general request drives `inta` high for `ACK_CYC` cycles, starting the cycle after `accept`, and `pending` stays low throughout. `ack_opcode` is sampled in the last `inta` cycle. In the cycle after it, `vec_valid` is high and `vector` equals opcode bits [5:3] times 8.
- R9: An `accept` while `pending` is low is ignored. No `vec_valid` or `inta` follows, and the global enable is left as it was.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_in | input | 1 | Non-maskable trap request |
| irq_edge_in | input | 1 | Edge-sensitive restart request, highest maskable |
| irq_mid_in | input | 1 | Level-sensitive restart request, middle |
| irq_low_in | input | 1 | Level-sensitive restart request, lowest |
| gen_irq_in | input | 1 | General request with device-supplied opcode |
| ie_set | input | 1 | Pulse: set global enable |
| ie_clr | input | 1 | Pulse: clear global enable |
| mask_wr | input | 1 | Pulse: load restart masks |
| mask_data | input | 3 | Mask values (bit2 edge, bit1 mid, bit0 low) |
| edge_clr | input | 1 | Pulse: discard a latched edge request |
| accept | input | 1 | Pulse from core: take the pending interrupt |
| ack_opcode | input | 8 | Restart opcode returned during acknowledge |
| pending | output | 1 | An interrupt is ready to be taken |
| vector | output | 16 | Service address of the taken interrupt |
| vec_valid | output | 1 | One-cycle strobe marking `vector` as new |
| inta | output | 1 | Acknowledge strobe for the general request |

## Verification
The hardest situations to reach from the ports are a latched edge request that was captured while its source was masked, and a trap that is withdrawn one cycle after it rose. Both depend on the timing of an edge against the mask writes and the sample point. The bench therefore drives edges at chosen cycles, relative to mask writes and clear pulses, before it looks at `pending`. The main sweep covers every mask value against every combination of the four maskable requests. It predicts the winner and vector arithmetically, and the general-request opcode is derived from the mask index so that each sweep point checks a different vector.

// File: rtl/vint_pkg.sv
package vint_pkg;

    localparam int VEC_W = 16;
    localparam int OPC_W = 8;

    localparam logic [VEC_W-1:0] VEC_TRAP = 16'h0024;
    localparam logic [VEC_W-1:0] VEC_EDGE = 16'h003C;
    localparam logic [VEC_W-1:0] VEC_MID  = 16'h0034;
    localparam logic [VEC_W-1:0] VEC_LOW  = 16'h002C;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_TRAP,
        SRC_EDGE,
        SRC_MID,
        SRC_LOW,
        SRC_GEN
    } src_e;

    // qualified requests, field order is the priority order (MSB wins)
    typedef struct packed {
        logic trap;
        logic edg;
        logic mid;
        logic low;
        logic gen;
    } req_s;

    localparam int NSRC = $bits(req_s);

    function automatic logic [VEC_W-1:0] fixed_vec(src_e s);
        case (s)
            SRC_TRAP: return VEC_TRAP;
            SRC_EDGE: return VEC_EDGE;
            SRC_MID:  return VEC_MID;
            SRC_LOW:  return VEC_LOW;
            default:  return '0;
        endcase
    endfunction

    // restart opcode: target index in bits [5:3], address = index * 8
    function automatic logic [VEC_W-1:0] opc_vec(logic [OPC_W-1:0] opc);
        return {{(VEC_W-6){1'b0}}, opc[5:3], 3'b000};
    endfunction

endpackage

// File: rtl/vint_capture.sv
module vint_capture (
    input  logic clk,
    input  logic rst,
    input  logic trap_in,
    input  logic edge_in,
    input  logic svc_trap,
    input  logic svc_edge,
    input  logic edge_clr,
    output logic trap_q,
    output logic edge_q
);
    logic trap_d, edge_d, trap_arm, edge_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_d   <= 1'b0;
            edge_d   <= 1'b0;
            trap_arm <= 1'b0;
            edge_lat <= 1'b0;
        end else begin
            trap_d <= trap_in;
            edge_d <= edge_in;
            if (svc_trap || !trap_in)
                trap_arm <= 1'b0;
            else if (!trap_d)
                trap_arm <= 1'b1;
            if (svc_edge || edge_clr)
                edge_lat <= 1'b0;
            else if (edge_in && !edge_d)
                edge_lat <= 1'b1;
        end
    end

    // trap counts only after a rise that is still high one cycle later
    assign trap_q = trap_arm && trap_in;
    assign edge_q = edge_lat;

    AST_TRAP_SUSTAINED: assert property (@(posedge clk) disable iff (rst)
        trap_q |-> $past(trap_in)) else $error("trap qualified without prior high"); // R3

    AST_EDGE_HELD: assert property (@(posedge clk) disable iff (rst)
        edge_q && !svc_edge && !edge_clr |=> edge_q) else $error("edge latch lost"); // R4

endmodule

// File: rtl/vint_prio.sv
module vint_prio
    import vint_pkg::*;
(
    input  vint_pkg::req_s req,
    output vint_pkg::src_e win,
    output logic [NSRC-1:0] grant,
    output logic any
);
    logic [NSRC-1:0] flat;
    assign flat = req;

    // highest set bit wins; bit order follows req_s
    always_comb begin
        grant = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (flat[i] && grant == '0)
                grant[i] = 1'b1;
        end
    end

    always_comb begin
        unique case (1'b1)
            grant[4]: win = SRC_TRAP;
            grant[3]: win = SRC_EDGE;
            grant[2]: win = SRC_MID;
            grant[1]: win = SRC_LOW;
            grant[0]: win = SRC_GEN;
            default:  win = SRC_NONE;
        endcase
    end

    assign any = |flat;

endmodule

// File: rtl/vint_ack.sv
module vint_ack
    import vint_pkg::*;
#(
    parameter int ACK_CYC = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_fixed,
    input  logic [VEC_W-1:0] fixed_addr,
    input  logic             start_gen,
    input  logic [OPC_W-1:0] opcode,
    output logic             busy,
    output logic             inta,
    output logic             vec_valid,
    output logic [VEC_W-1:0] vector
);
    localparam int CNT_W = (ACK_CYC > 1) ? $clog2(ACK_CYC) : 1;

    typedef enum logic {ST_IDLE, ST_ACK} st_e;
    st_e              st;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            inta      <= 1'b0;
            vec_valid <= 1'b0;
            vector    <= '0;
        end else begin
            vec_valid <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start_gen) begin
                        st   <= ST_ACK;
                        inta <= 1'b1;
                        cnt  <= CNT_W'(ACK_CYC - 1);
                    end else if (start_fixed) begin
                        vector    <= fixed_addr;
                        vec_valid <= 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        st        <= ST_IDLE;
                        inta      <= 1'b0;
                        vector    <= opc_vec(opcode);
                        vec_valid <= 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (st == ST_ACK);

    AST_INTA_SPAN: assert property (@(posedge clk) disable iff (rst)
        inta && cnt != '0 |=> inta) else $error("acknowledge cut short"); // R8

    AST_VECTOR_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        $fell(inta) |-> vec_valid) else $error("no vector after acknowledge"); // R8

endmodule

// File: rtl/vint_ctrl.sv
module vint_ctrl
    import vint_pkg::*;
#(
    parameter int ACK_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trap_in,
    input  logic        irq_edge_in,
    input  logic        irq_mid_in,
    input  logic        irq_low_in,
    input  logic        gen_irq_in,
    input  logic        ie_set,
    input  logic        ie_clr,
    input  logic        mask_wr,
    input  logic [2:0]  mask_data,
    input  logic        edge_clr,
    input  logic        accept,
    input  logic [7:0]  ack_opcode,
    output logic        pending,
    output logic [15:0] vector,
    output logic        vec_valid,
    output logic        inta
);
    logic            ie_q;
    logic [2:0]      mask_q;
    logic            trap_q, edge_q, any, busy, take;
    logic            svc_trap, svc_edge, start_gen, start_fixed;
    req_s            req;
    src_e            win;
    logic [NSRC-1:0] grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q   <= 1'b0;
            mask_q <= '1;
        end else begin
            if (take || ie_clr)
                ie_q <= 1'b0;
            else if (ie_set)
                ie_q <= 1'b1;
            if (mask_wr)
                mask_q <= mask_data;
        end
    end

    vint_capture u_capture (
        .clk      (clk),
        .rst      (rst),
        .trap_in  (trap_in),
        .edge_in  (irq_edge_in),
        .svc_trap (svc_trap),
        .svc_edge (svc_edge),
        .edge_clr (edge_clr),
        .trap_q   (trap_q),
        .edge_q   (edge_q)
    );

    always_comb begin
        req.trap = trap_q;
        req.edg  = edge_q     && !mask_q[2] && ie_q;
        req.mid  = irq_mid_in && !mask_q[1] && ie_q;
        req.low  = irq_low_in && !mask_q[0] && ie_q;
        req.gen  = gen_irq_in && ie_q;
    end

    vint_prio u_prio (
        .req   (req),
        .win   (win),
        .grant (grant),
        .any   (any)
    );

    assign pending     = any && !busy;
    assign take        = accept && pending;
    assign svc_trap    = take && (win == SRC_TRAP);
    assign svc_edge    = take && (win == SRC_EDGE);
    assign start_gen   = take && (win == SRC_GEN);
    assign start_fixed = take && (win != SRC_GEN);

    vint_ack #(.ACK_CYC(ACK_CYC)) u_ack (
        .clk         (clk),
        .rst         (rst),
        .start_fixed (start_fixed),
        .fixed_addr  (fixed_vec(win)),
        .start_gen   (start_gen),
        .opcode      (ack_opcode),
        .busy        (busy),
        .inta        (inta),
        .vec_valid   (vec_valid),
        .vector      (vector)
    );

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)) else $error("several sources granted"); // R2

    AST_FIXED_STROBE: assert property (@(posedge clk) disable iff (rst)
        take && win != SRC_GEN |=> vec_valid) else $error("fixed vector missing"); // R2

    AST_TRAP_FIRST: assert property (@(posedge clk) disable iff (rst)
        trap_q && !busy |-> pending && win == SRC_TRAP) else $error("trap not first"); // R3

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !ie_q && !trap_q |-> !pending) else $error("request while disabled"); // R7

    AST_IE_DROP: assert property (@(posedge clk) disable iff (rst)
        take |=> !ie_q) else $error("enable kept after accept"); // R7

    AST_NO_PEND_IN_ACK: assert property (@(posedge clk) disable iff (rst)
        inta |-> !pending) else $error("pending during acknowledge"); // R8

    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept && !pending && !busy |=> !vec_valid && !inta) else $error("spurious accept acted"); // R9

endmodule

// File: tb/vint_ctrl_bench.sv
module vint_ctrl_bench;
    localparam int ACK = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trap_in = 0, irq_edge_in = 0, irq_mid_in = 0, irq_low_in = 0, gen_irq_in = 0;
    logic        ie_set = 0, ie_clr = 0, mask_wr = 0, edge_clr = 0, accept = 0;
    logic [2:0]  mask_data = '0;
    logic [7:0]  ack_opcode = '0;
    logic        pending, vec_valid, inta;
    logic [15:0] vector;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vint_ctrl #(.ACK_CYC(ACK)) u_vint_ctrl (
        .clk(clk), .rst(rst), .trap_in(trap_in), .irq_edge_in(irq_edge_in),
        .irq_mid_in(irq_mid_in), .irq_low_in(irq_low_in), .gen_irq_in(gen_irq_in),
        .ie_set(ie_set), .ie_clr(ie_clr), .mask_wr(mask_wr), .mask_data(mask_data),
        .edge_clr(edge_clr), .accept(accept), .ack_opcode(ack_opcode),
        .pending(pending), .vector(vector), .vec_valid(vec_valid), .inta(inta)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic clear_inputs();
        trap_in = 0; irq_edge_in = 0; irq_mid_in = 0; irq_low_in = 0; gen_irq_in = 0;
        ie_set = 0; ie_clr = 0; mask_wr = 0; edge_clr = 0; accept = 0;
    endtask

    task automatic do_reset();
        clear_inputs();
        rst = 1;
        step(); step();
        rst = 0;
        step();
    endtask

    task automatic set_mask(input logic [2:0] m);
        mask_wr = 1; mask_data = m; step(); mask_wr = 0;
    endtask

    task automatic enable();
        ie_set = 1; step(); ie_set = 0;
    endtask

    task automatic take_fixed(input string req, input logic [15:0] exp_vec);
        accept = 1; step(); accept = 0;
        chk(req, {15'b0, vec_valid}, 16'd1);
        chk(req, vector, exp_vec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state and default masks
        do_reset();
        chk("R1 pending", {15'b0, pending}, 16'd0);
        chk("R1 inta", {15'b0, inta}, 16'd0);
        chk("R1 vec_valid", {15'b0, vec_valid}, 16'd0);
        chk("R1 vector", vector, 16'h0000);
        enable();
        irq_mid_in = 1; irq_low_in = 1; irq_edge_in = 1;
        step(); step();
        chk("R1 masks set after reset", {15'b0, pending}, 16'd0);
        // R4: edge captured while masked, served after unmask
        set_mask(3'b011);
        step();
        chk("R4 latched while masked", {15'b0, pending}, 16'd1);
        take_fixed("R4 edge vector", 16'h003C);
        enable();
        set_mask(3'b111);
        irq_mid_in = 0; irq_low_in = 0;
        set_mask(3'b011);
        step();
        chk("R4 held level no retrigger", {15'b0, pending}, 16'd0);

        // R4: edge_clr discards a latched edge
        do_reset();
        enable();
        irq_edge_in = 1; step(); irq_edge_in = 0;
        edge_clr = 1; step(); edge_clr = 0;
        set_mask(3'b000);
        step();
        chk("R4 edge_clr discards", {15'b0, pending}, 16'd0);

        // R3: trap with enable off and masks set
        do_reset();
        trap_in = 1; step();
        chk("R3 trap qualifies after sustained high", {15'b0, pending}, 16'd1);
        irq_edge_in = 1; step();
        take_fixed("R3 trap vector over others", 16'h0024);
        step();
        chk("R3 held trap no retrigger", {15'b0, pending}, 16'd0);
        trap_in = 0; step();
        trap_in = 1; step();
        chk("R3 new rise retriggers", {15'b0, pending}, 16'd1);
        // R3: trap withdrawn after one cycle
        do_reset();
        trap_in = 1; step();
        trap_in = 0; #1;
        chk("R3 short trap pending", {15'b0, pending}, 16'd0);
        step();
        chk("R3 short trap dropped", {15'b0, pending}, 16'd0);

        // R5/R7: level sources need enable
        do_reset();
        set_mask(3'b000);
        irq_mid_in = 1; gen_irq_in = 1; step();
        chk("R7 disabled blocks", {15'b0, pending}, 16'd0);
        enable();
        chk("R7 enabled allows", {15'b0, pending}, 16'd1);
        irq_mid_in = 0; #1;
        chk("R5 mid dropped falls to gen", {15'b0, pending}, 16'd1);
        ie_clr = 1; step(); ie_clr = 0;
        chk("R7 ie_clr blocks gen", {15'b0, pending}, 16'd0);
        // R9: accept with nothing pending
        accept = 1; step(); accept = 0;
        chk("R9 no vec_valid", {15'b0, vec_valid}, 16'd0);
        chk("R9 no inta", {15'b0, inta}, 16'd0);
        enable();
        accept = 1; gen_irq_in = 0; step(); accept = 0;
        gen_irq_in = 1; #1;
        chk("R9 enable kept after idle accept", {15'b0, pending}, 16'd1);
        // R7: accept wins over ie_set
        gen_irq_in = 0; irq_low_in = 1; #1;
        accept = 1; ie_set = 1; step(); accept = 0; ie_set = 0;
        chk("R7 accept beats ie_set vector", vector, 16'h002C);
        step();
        chk("R7 accept beats ie_set", {15'b0, pending}, 16'd0);

        // R2/R5/R6/R8 sweep: all masks x all request combos
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 16; c++) begin
                logic [2:0]  mm;
                logic [15:0] ev;
                logic        any_exp, gen_win;
                mm = m[2:0];
                do_reset();
                set_mask(mm);
                enable();
                irq_edge_in = c[3]; irq_mid_in = c[2]; irq_low_in = c[1]; gen_irq_in = c[0];
                ack_opcode = {2'b11, mm, 3'b111};
                step();
                gen_win = 1'b0;
                any_exp = 1'b1;
                if (c[3] && !mm[2])      ev = 16'h003C;
                else if (c[2] && !mm[1]) ev = 16'h0034;
                else if (c[1] && !mm[0]) ev = 16'h002C;
                else if (c[0]) begin ev = {10'b0, mm, 3'b000}; gen_win = 1'b1; end
                else begin ev = 16'h0; any_exp = 1'b0; end
                chk("R6 R5 pending", {15'b0, pending}, {15'b0, any_exp});
                accept = 1; step(); accept = 0;
                if (!any_exp) begin
                    chk("R9 sweep no strobe", {14'b0, vec_valid, inta}, 16'd0);
                end else if (gen_win) begin
                    for (int k = 0; k < ACK; k++) begin
                        chk("R8 inta high", {15'b0, inta}, 16'd1);
                        chk("R8 no pending in ack", {15'b0, pending}, 16'd0);
                        chk("R8 no early vector", {15'b0, vec_valid}, 16'd0);
                        step();
                    end
                    chk("R8 inta done", {15'b0, inta}, 16'd0);
                    chk("R8 vec_valid", {15'b0, vec_valid}, 16'd1);
                    chk("R8 opcode vector", vector, ev);
                end else begin
                    chk("R2 vec_valid", {15'b0, vec_valid}, 16'd1);
                    chk("R2 priority vector", vector, ev);
                    chk("R2 no inta", {15'b0, inta}, 16'd0);
                end
                chk("R7 disabled after accept", {15'b0, pending}, 16'd0);
                clear_inputs();
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule